// File: doc/BRIEF.md
# Envelope Segment Sequencer Controller

This block is the control state machine for a multi-segment envelope generator. It holds a three-bit segment index where 0 means Ready (ramp engine held at zero, no segment's slope or threshold selected) and 1 to 7 name the active segment. The ramp arithmetic and the sustain timer sit outside; they send advance requests in and take the segment index, a one-hot segment select and the Ready hold back out.

A rising gate, from either the gate input or the manual gate button, restarts the envelope. The index goes to Ready for one cycle and is then loaded with segment 1, and any advance request that lands in those two cycles is lost. Each advance request steps to the next segment. The envelope ends either by wrapping from segment 7 or by a clear once the selected segment count has been passed. An optional repeat starts the envelope again after a fixed stay in Ready. Sustain segments hold while the gate is high. A second gate mode aborts the envelope when the gate is released. A runaway request from the ramp engine forces Ready.

The gate, manual gate, advance, sustain-active, sustain-done and runaway inputs pass through two-flop synchronizers, and edges are taken on the synchronized copies. A change on one of these pins therefore reaches the segment index on the third rising clock edge. The segment count, repeat enable and gate mode are treated as quasi-static settings and are not synchronized.

Top module: `envseq_top`

## Requirements
- R1: While reset is asserted and after it is released with no other activity, segIdx is 0, ready is 1 and segOneHot is all zeros.
- R2: A rising edge of (gateIn OR manGateIn) puts segIdx at 0 on the third clock edge after the change and at 1 on the fourth, from any state, including in the middle of an envelope.
- R3: A rising advPulse whose synchronized edge falls on the clear step or the load step of a gate restart is discarded, so segIdx is 1 after the restart and stays there.
- R4: Each rising advPulse moves segIdx to segIdx+1 on the third edge. With segCount N from 2 to 6 (values 0 and 1 act as 2), an advance from segment N, or any cycle with segIdx above N, gives segIdx 0. With N = 7, an advance from segment 7 wraps to 0.
- R5: With repeatEn = 1, after segIdx enters 0 it stays there for REPEAT_DLY cycles and then becomes 1 without any input. With repeatEn = 0 it stays at 0.
- R6: While sustainActive = 1 and the gate is high, a rising sustainDone has no effect on segIdx. With the gate low it advances one segment.
- R7: With gateMode = 0, a falling gate while sustainActive = 1 in a segment advances segIdx by one on the third edge.
- R8: With gateMode = 1, a falling gate while in any segment (sustaining or not) returns segIdx to 0 on the third edge.
- R9: While runawayReq is high, segIdx is forced to 0 and advance pulses have no effect.
- R10: Events in the same cycle are resolved in this order: gate restart (including its load step), runaway, gate-mode-1 release, segment-count clear, advance. At most one action is applied per cycle.
- R11: segOneHot bit k-1 is set exactly when segIdx = k (k = 1..7), and ready is 1 exactly when segIdx = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| gateIn | input | 1 | Clean external gate level |
| manGateIn | input | 1 | Clean manual gate button level |
| advPulse | input | 1 | Segment-end request from the ramp comparator; the rising edge counts |
| sustainActive | input | 1 | Active segment is set to sustain |
| sustainDone | input | 1 | Sustain timer expired; the rising edge counts |
| runawayReq | input | 1 | Ramp left its legal window; level forces Ready |
| segCount | input | 3 | Number of segments, 2 to 7 |
| repeatEn | input | 1 | Restart the envelope automatically after Ready |
| gateMode | input | 1 | 0: release only ends sustain; 1: release aborts to Ready |
| segIdx | output | 3 | Active segment, 0 = Ready |
| segOneHot | output | 7 | One-hot segment select, bit k-1 for segment k |
| ready | output | 1 | High in Ready; holds the ramp engine at zero |

## Verification
Advance pulses are stepped through full envelopes with the count set to 7, 3 and 0. This separates a natural wrap from an early clear and confirms that small count values clamp to 2. Gate restarts are tried alone, from the manual button, mid-envelope, and together with an advance pulse landing on the clear step or on the load step, so that a lost load can be told apart from a double step. Sustain-done pulses are sent with the gate high and with it low. Gate release is sent in both modes, from sustain and from a plain segment. A runaway arriving together with a gate shows the restart load winning before the runaway clear takes over. The repeat delay is checked one cycle before and exactly at the expected re-entry, and again with repeat disabled.

// File: rtl/envseq_pkg.sv
package envseq_pkg;
  localparam int IDX_W   = 3;
  localparam int NUM_SEG = (1 << IDX_W) - 1;
  localparam int NUM_IN  = 6;

  // positions in the synchronized input vector
  localparam int IN_GATE = 0;
  localparam int IN_MAN  = 1;
  localparam int IN_ADV  = 2;
  localparam int IN_SUS  = 3;
  localparam int IN_DONE = 4;
  localparam int IN_RUN  = 5;

  typedef struct packed {
    logic load;   // put segment 1 in place
    logic clr;    // return to Ready
    logic adv;    // step to the next segment
  } seqStrobe_t;
endpackage

// File: rtl/envseq_sync.sv
module envseq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= din[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/envseq_ctrl.sv
module envseq_ctrl
  import envseq_pkg::*;
#(
  parameter int REPEAT_DLY = 30000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] syncIn,
  input  logic [IDX_W-1:0]  segIdx,
  input  logic [IDX_W-1:0]  segCount,
  input  logic              repeatEn,
  input  logic              gateMode,
  output seqStrobe_t        stb
);
  localparam int DLY_W = $clog2(REPEAT_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(REPEAT_DLY - 1);
  localparam logic [IDX_W-1:0] MIN_CNT  = IDX_W'(2);
  localparam logic [IDX_W-1:0] FULL_CNT = IDX_W'(NUM_SEG);

  logic gateNow, gatePrev, advPrev, donePrev;
  logic gateRise, gateFall, advRise, doneRise;
  logic loadPend;
  logic [DLY_W-1:0] dlyCnt;
  logic inSeg, susOn, runOn, repFire, advReq;
  logic [IDX_W-1:0] effCnt;
  logic limitOn;

  assign gateNow  = syncIn[IN_GATE] | syncIn[IN_MAN];
  assign susOn    = syncIn[IN_SUS];
  assign runOn    = syncIn[IN_RUN];
  assign gateRise = gateNow & ~gatePrev;
  assign gateFall = ~gateNow & gatePrev;
  assign advRise  = syncIn[IN_ADV] & ~advPrev;
  assign doneRise = syncIn[IN_DONE] & ~donePrev;
  assign inSeg    = (segIdx != '0);

  assign effCnt   = (segCount < MIN_CNT) ? MIN_CNT : segCount;
  assign limitOn  = (effCnt != FULL_CNT);
  assign repFire  = repeatEn && !inSeg && (dlyCnt == DLY_LAST);

  assign advReq = advRise
                | (doneRise & susOn & ~gateNow & inSeg)
                | (gateFall & susOn & inSeg)
                | repFire;

  always_comb begin
    stb = '0;
    if (loadPend)                         stb.load = 1'b1;
    else if (gateRise)                    stb.clr  = 1'b1;
    else if (runOn)                       stb.clr  = 1'b1;
    else if (gateMode && gateFall && inSeg) stb.clr = 1'b1;
    else if (limitOn && segIdx > effCnt)  stb.clr  = 1'b1;
    else if (advReq) begin
      if (limitOn && segIdx == effCnt)    stb.clr  = 1'b1;
      else                                stb.adv  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gatePrev <= 1'b0;
      advPrev  <= 1'b0;
      donePrev <= 1'b0;
      loadPend <= 1'b0;
      dlyCnt   <= '0;
    end else begin
      gatePrev <= gateNow;
      advPrev  <= syncIn[IN_ADV];
      donePrev <= syncIn[IN_DONE];
      loadPend <= gateRise & ~loadPend;
      if (inSeg || loadPend || !repeatEn || repFire) dlyCnt <= '0;
      else                                          dlyCnt <= dlyCnt + 1'b1;
    end
  end
endmodule

// File: rtl/envseq_dp.sv
module envseq_dp
  import envseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  output logic [IDX_W-1:0]   segIdx,
  output logic [NUM_SEG-1:0] segOneHot,
  output logic               ready
);
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (stb.load) cnt <= IDX_W'(1);
    else if (stb.clr)  cnt <= '0;
    else if (stb.adv)  cnt <= cnt + 1'b1;   // 7 rolls over to Ready
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_sel
    assign segOneHot[k] = (cnt == IDX_W'(k + 1));
  end

  assign segIdx = cnt;
  assign ready  = (cnt == '0);
endmodule

// File: rtl/envseq_top.sv
module envseq_top
  import envseq_pkg::*;
#(
  parameter int REPEAT_DLY = 30000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               gateIn,
  input  logic               manGateIn,
  input  logic               advPulse,
  input  logic               sustainActive,
  input  logic               sustainDone,
  input  logic               runawayReq,
  input  logic [IDX_W-1:0]   segCount,
  input  logic               repeatEn,
  input  logic               gateMode,
  output logic [IDX_W-1:0]   segIdx,
  output logic [NUM_SEG-1:0] segOneHot,
  output logic               ready
);
  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  seqStrobe_t        stb;

  always_comb begin
    rawIn          = '0;
    rawIn[IN_GATE] = gateIn;
    rawIn[IN_MAN]  = manGateIn;
    rawIn[IN_ADV]  = advPulse;
    rawIn[IN_SUS]  = sustainActive;
    rawIn[IN_DONE] = sustainDone;
    rawIn[IN_RUN]  = runawayReq;
  end

  envseq_sync #(.W(NUM_IN)) sync_i (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncIn)
  );

  envseq_ctrl #(.REPEAT_DLY(REPEAT_DLY)) ctrl_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .segIdx(segIdx),
    .segCount(segCount), .repeatEn(repeatEn), .gateMode(gateMode), .stb(stb)
  );

  envseq_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .segIdx(segIdx), .segOneHot(segOneHot), .ready(ready)
  );
endmodule

// File: rtl/envseq_chk.sv
module envseq_chk
  import envseq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [IDX_W-1:0]   segCount,
  input logic [IDX_W-1:0]   segIdx,
  input logic [NUM_SEG-1:0] segOneHot,
  input logic               ready,
  input seqStrobe_t         stb
);
  AST_ONEHOT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(segOneHot)); // R11

  AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ready == (segOneHot == '0)); // R11

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (segIdx != $past(segIdx)) |->
      (segIdx == 3'd0 || segIdx == 3'd1 || segIdx == $past(segIdx) + 3'd1)); // R4

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.adv |=> (segIdx == $past(segIdx) + 3'd1)); // R4

  AST_SEG_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (segCount >= 3'd2 && segCount <= 3'd6 && $past(segCount) == segCount)
      |-> (segIdx <= segCount)); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (segIdx == 3'd1)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> ready); // R9

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.clr, stb.adv})); // R10
endmodule

bind envseq_top envseq_chk chk_i (
  .clk(clk), .rstN(rstN), .segCount(segCount), .segIdx(segIdx),
  .segOneHot(segOneHot), .ready(ready), .stb(stb)
);

// File: tb/envseq_top_tb_top.sv
module envseq_top_tb_top;
  localparam int DLY = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateIn = 0, manGateIn = 0, advPulse = 0, sustainActive = 0;
  logic sustainDone = 0, runawayReq = 0, repeatEn = 0, gateMode = 0;
  logic [2:0] segCount = 3'd7;
  logic [2:0] segIdx;
  logic [6:0] segOneHot;
  logic ready;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    int       at;
    logic [2:0] idx;
    string    tag;
  } expItem_t;
  expItem_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  envseq_top #(.REPEAT_DLY(DLY)) dut_i (
    .clk(clk), .rstN(rstN), .gateIn(gateIn), .manGateIn(manGateIn),
    .advPulse(advPulse), .sustainActive(sustainActive), .sustainDone(sustainDone),
    .runawayReq(runawayReq), .segCount(segCount), .repeatEn(repeatEn),
    .gateMode(gateMode), .segIdx(segIdx), .segOneHot(segOneHot), .ready(ready)
  );

  // monitor: pops expectations that fall due in this cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      automatic expItem_t it = sbq.pop_front();
      automatic logic [6:0] expOh = (it.idx == 0) ? 7'd0 : (7'd1 << (it.idx - 1));
      automatic logic expRdy = (it.idx == 0);
      compared++;
      if (it.at != cyc || segIdx !== it.idx || segOneHot !== expOh || ready !== expRdy) begin
        mismatched++;
        $display("FAIL %s (R11 outputs): idx=%0d ready=%0b oh=%b expected idx=%0d ready=%0b oh=%b",
                 it.tag, segIdx, ready, segOneHot, it.idx, expRdy, expOh);
      end
    end
  end

  task automatic expectAt(input int off, input logic [2:0] idx, input string tag);
    sbq.push_back('{at: cyc + off, idx: idx, tag: tag});
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic advStep(input logic [2:0] idx, input string tag);
    expectAt(3, idx, tag);
    advPulse = 1'b1;
    tick(1);
    advPulse = 1'b0;
    tick(5);
  endtask

  task automatic restart(input string tag);
    gateIn = 1'b0;
    tick(4);
    expectAt(3, 3'd0, tag);
    expectAt(4, 3'd1, tag);
    gateIn = 1'b1;
    tick(6);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    tick(3);
    expectAt(0, 3'd0, "R1 during reset");
    tick(1);
    rstN = 1'b1;
    expectAt(1, 3'd0, "R1 after reset");
    tick(4);

    // full envelope, 7 segments with wrap
    restart("R2 first gate");
    for (int k = 2; k <= 7; k++) advStep(3'(k), "R4 step up");
    advStep(3'd0, "R4 wrap from 7");

    // mid-envelope restart
    restart("R2 restart");
    advStep(3'd2, "R4 step");
    advStep(3'd3, "R4 step");
    restart("R2 mid-envelope restart");

    // advance on the clear step
    advStep(3'd2, "R4 step");
    gateIn = 1'b0;
    tick(4);
    expectAt(3, 3'd0, "R3 clear step");
    expectAt(4, 3'd1, "R3 adv on clear step");
    expectAt(6, 3'd1, "R3 adv on clear step held");
    gateIn = 1'b1;
    advPulse = 1'b1;
    tick(1);
    advPulse = 1'b0;
    tick(6);

    // advance on the load step
    advStep(3'd2, "R4 step");
    gateIn = 1'b0;
    tick(4);
    expectAt(3, 3'd0, "R3 clear step");
    expectAt(4, 3'd1, "R3 adv on load step");
    expectAt(6, 3'd1, "R3 adv on load step held");
    gateIn = 1'b1;
    tick(1);
    advPulse = 1'b1;
    tick(1);
    advPulse = 1'b0;
    tick(6);

    // manual gate
    advStep(3'd2, "R4 step");
    gateIn = 1'b0;
    tick(4);
    expectAt(3, 3'd0, "R2 manual gate clear");
    expectAt(4, 3'd1, "R2 manual gate load");
    manGateIn = 1'b1;
    tick(6);
    manGateIn = 1'b0;
    tick(6);

    // three segments: early clear
    segCount = 3'd3;
    restart("R2 restart n3");
    advStep(3'd2, "R4 n3 step");
    advStep(3'd3, "R4 n3 step");
    advStep(3'd0, "R4 n3 early clear");

    // count 0 acts as 2
    segCount = 3'd0;
    restart("R2 restart n0");
    advStep(3'd2, "R4 n0 step");
    advStep(3'd0, "R4 n0 clamps to 2");

    // repeat
    segCount = 3'd2;
    restart("R2 restart repeat");
    repeatEn = 1'b1;
    advStep(3'd2, "R4 step");
    expectAt(3 + DLY - 1, 3'd0, "R5 still ready before delay");
    expectAt(3 + DLY, 3'd1, "R5 repeat re-entry");
    advPulse = 1'b1;
    tick(1);
    advPulse = 1'b0;
    tick(DLY + 10);
    repeatEn = 1'b0;
    advStep(3'd2, "R4 step");
    expectAt(3 + DLY + 5, 3'd0, "R5 no repeat when disabled");
    advPulse = 1'b1;
    tick(1);
    advPulse = 1'b0;
    tick(DLY + 10);

    // sustain
    segCount = 3'd7;
    restart("R2 restart sustain");
    sustainActive = 1'b1;
    tick(4);
    expectAt(3, 3'd1, "R6 done blocked while gate high");
    expectAt(6, 3'd1, "R6 done blocked while gate high later");
    sustainDone = 1'b1;
    tick(1);
    sustainDone = 1'b0;
    tick(6);
    expectAt(3, 3'd2, "R7 release in sustain advances");
    gateIn = 1'b0;
    tick(6);
    expectAt(3, 3'd3, "R6 done advances with gate low");
    sustainDone = 1'b1;
    tick(1);
    sustainDone = 1'b0;
    tick(6);
    sustainActive = 1'b0;
    tick(4);

    // gate mode 2
    gateMode = 1'b1;
    restart("R2 restart mode 2");
    advStep(3'd2, "R4 step");
    expectAt(3, 3'd0, "R8 release aborts");
    gateIn = 1'b0;
    tick(6);
    restart("R2 restart mode 2 sustain");
    sustainActive = 1'b1;
    tick(4);
    expectAt(3, 3'd0, "R8 release from sustain aborts");
    gateIn = 1'b0;
    tick(6);
    sustainActive = 1'b0;
    gateMode = 1'b0;
    tick(4);

    // runaway
    restart("R2 restart runaway");
    advStep(3'd2, "R4 step");
    expectAt(3, 3'd0, "R9 runaway clears");
    runawayReq = 1'b1;
    tick(6);
    expectAt(3, 3'd0, "R9 advance ignored in runaway");
    expectAt(6, 3'd0, "R9 advance ignored in runaway later");
    advPulse = 1'b1;
    tick(1);
    advPulse = 1'b0;
    tick(6);
    runawayReq = 1'b0;
    tick(4);

    // gate and runaway together
    gateIn = 1'b0;
    tick(6);
    expectAt(3, 3'd0, "R10 restart clear");
    expectAt(4, 3'd1, "R10 load beats runaway");
    expectAt(5, 3'd0, "R10 runaway after load");
    gateIn = 1'b1;
    runawayReq = 1'b1;
    tick(7);
    runawayReq = 1'b0;
    tick(10);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule